// File: doc/BRIEF.md
# Command Ring Method Decoder

This block drains a ring of 32-bit command words that a host fills in memory, and turns them into method writes on bound objects. The host moves a write pointer forward through a small control port. The block owns the read pointer. Whenever the two differ, it fetches one word per cycle through a synchronous read port.

Every command begins with a header word. The header names a subchannel, a starting method offset and a dword count. That many data words follow. Each data word goes out as a method write. Successive data words go to successive method addresses, four bytes apart, on the object handle bound to the subchannel. A data word whose current method address is zero binds its value as the new handle of the subchannel and produces no write.

Handle translation, object execution and DMA belong to the blocks downstream of the method interface.

Top module: `cmd_fifo_decoder`

## Requirements
- R1: After reset both pointers read 0, `idle_o` is 1, and neither `mth_valid_o` nor `err_o` is asserted.
- R2: A control write to byte offset 0x40 loads the write pointer. Reads of 0x40 and 0x44 return the write and read pointers, both counted in words. A control write to 0x44 has no effect, and a read of any other offset returns 0.
- R3: While the read pointer differs from the write pointer, the block issues one memory read per cycle at the read-pointer address and advances the pointer. `idle_o` is 1 only when the pointers are equal and no word is in flight. A burst of N words reaches idle N+1 cycles after the pointer update takes effect.
- R4: The read pointer wraps from RING_WORDS-1 to 0.
- R5: A header decodes as follows:
  - count = bits 28:18
  - subchannel = bits 15:13
  - method byte offset = bits 12:2 followed by two zero bits
- R6: The k-th data word after a header with method offset M goes out as a write. The write carries address M+4k, the header's subchannel, the handle bound to that subchannel, and the word itself. It appears two clock edges after its fetch request.
- R7: A data word at method address 0 binds its value to the subchannel and emits no write. Any further data words of the same command continue at address 4 on the newly bound handle.
- R8: An all-zero word read where a header is expected is a no-op. It consumes one ring slot and causes no output.
- R9: A data word for a nonzero method on a subchannel that has never been bound drops the write. It pulses `err_o` for one cycle, with `mth_valid_o` low.
- R10: A later bind replaces the handle of that subchannel. Bindings of other subchannels are unaffected.
- R11: A command may be split across write-pointer updates. The decode state is kept while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_addr_i | input | 8 | Control byte offset |
| ctrl_wdata_i | input | 32 | Control write data |
| ctrl_rdata_o | output | 32 | Control read data (combinational) |
| mem_req_o | output | 1 | Ring read request |
| mem_addr_o | output | PTR_W | Ring word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| mth_valid_o | output | 1 | Method write strobe |
| mth_subch_o | output | 3 | Subchannel of the write |
| mth_addr_o | output | 13 | Method byte address |
| mth_handle_o | output | 32 | Bound object handle |
| mth_data_o | output | 32 | Method data |
| err_o | output | 1 | Write to an unbound subchannel dropped |
| idle_o | output | 1 | Pointers equal and nothing in flight |

## Verification
The streams tried are:
- a command to an unbound subchannel, which separates dropped writes from real ones;
- a one-word bind followed by a multi-word burst, which exposes wrong address stepping or stale handles;
- no-op words spliced between commands;
- a two-word command that binds and then writes in one go;
- a rebind of one subchannel while another stays bound;
- a command whose header and data arrive under separate pointer updates.

Together these streams run the ring past its end, so pointer wrap and address wrap are exercised. Reads of the pointers through the control port after each stream, together with exact idle timing, tell a one-word-per-cycle fetcher apart from a slower one.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int unsigned SUBCH_N = 8;
  localparam int unsigned SUBCH_W = $clog2(SUBCH_N);
  localparam int unsigned CNT_W   = 11;
  localparam int unsigned MTH_W   = 11;
  localparam logic [7:0]  PUT_OFS = 8'h40;
  localparam logic [7:0]  GET_OFS = 8'h44;

  typedef struct packed {
    logic [CNT_W-1:0]   count;
    logic [SUBCH_W-1:0] subch;
    logic [MTH_W-1:0]   mth;
  } cmd_hdr_t;

  function automatic cmd_hdr_t hdr_decode(input logic [31:0] w);
    cmd_hdr_t h;
    h.count = w[28:18];
    h.subch = w[15:13];
    h.mth   = w[12:2];
    return h;
  endfunction
endpackage

// File: rtl/cfd_fetch.sv
module cfd_fetch #(
  parameter int unsigned RING_WORDS = 64,
  localparam int unsigned PTR_W = $clog2(RING_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             put_we_i,
  input  logic [PTR_W-1:0] put_i,
  output logic [PTR_W-1:0] put_o,
  output logic [PTR_W-1:0] get_o,
  output logic             mem_req_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic             word_vld_o,
  output logic             idle_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RING_WORDS - 1);

  logic [PTR_W-1:0] put_q, get_q;
  logic             pend_q;
  logic             issue;

  assign issue = (get_q != put_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      put_q  <= '0;
      get_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (put_we_i) put_q <= put_i;
      if (issue) get_q <= (get_q == LAST) ? '0 : get_q + 1'b1;
      pend_q <= issue;
    end
  end

  assign put_o      = put_q;
  assign get_o      = get_q;
  assign mem_req_o  = issue;
  assign mem_addr_o = get_q;
  assign word_vld_o = pend_q;
  assign idle_o     = !issue && !pend_q;
endmodule

// File: rtl/cfd_bind_slot.sv
module cfd_bind_slot (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] handle_i,
  output logic [31:0] handle_o,
  output logic        bound_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      handle_o <= '0;
      bound_o  <= 1'b0;
    end else if (we_i) begin
      handle_o <= handle_i;
      bound_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/cfd_decode.sv
module cfd_decode
  import cfd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_vld_i,
  input  logic [31:0]        word_i,
  output logic               mth_valid_o,
  output logic [SUBCH_W-1:0] mth_subch_o,
  output logic [12:0]        mth_addr_o,
  output logic [31:0]        mth_handle_o,
  output logic [31:0]        mth_data_o,
  output logic               err_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [SUBCH_W-1:0] sc_q;
  logic [MTH_W-1:0]   mth_q;
  cmd_hdr_t           hdr;
  logic               is_hdr, is_dat, bind_we, wr_ok, wr_bad;

  logic [SUBCH_N-1:0][31:0] slot_handle;
  logic [SUBCH_N-1:0]       slot_bound;

  for (genvar g = 0; g < SUBCH_N; g++) begin : g_slot
    cfd_bind_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (bind_we && (sc_q == SUBCH_W'(g))),
      .handle_i (word_i),
      .handle_o (slot_handle[g]),
      .bound_o  (slot_bound[g])
    );
  end

  always_comb begin
    hdr     = hdr_decode(word_i);
    is_hdr  = word_vld_i && (cnt_q == '0);
    is_dat  = word_vld_i && (cnt_q != '0);
    bind_we = is_dat && (mth_q == '0);
    wr_ok   = is_dat && (mth_q != '0) && slot_bound[sc_q];
    wr_bad  = is_dat && (mth_q != '0) && !slot_bound[sc_q];
  end

  // an all-zero header decodes to count 0: nothing follows, i.e. a no-op
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sc_q  <= '0;
      mth_q <= '0;
    end else if (is_hdr) begin
      cnt_q <= hdr.count;
      sc_q  <= hdr.subch;
      mth_q <= hdr.mth;
    end else if (is_dat) begin
      cnt_q <= cnt_q - 1'b1;
      mth_q <= mth_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mth_valid_o  <= 1'b0;
      err_o        <= 1'b0;
      mth_subch_o  <= '0;
      mth_addr_o   <= '0;
      mth_handle_o <= '0;
      mth_data_o   <= '0;
    end else begin
      mth_valid_o <= wr_ok;
      err_o       <= wr_bad;
      if (wr_ok) begin
        mth_subch_o  <= sc_q;
        mth_addr_o   <= {mth_q, 2'b00};
        mth_handle_o <= slot_handle[sc_q];
        mth_data_o   <= word_i;
      end
    end
  end
endmodule

// File: rtl/cmd_fifo_decoder.sv
module cmd_fifo_decoder
  import cfd_pkg::*;
#(
  parameter int unsigned RING_WORDS = 64,
  localparam int unsigned PTR_W = $clog2(RING_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_addr_i,
  input  logic [31:0]      ctrl_wdata_i,
  output logic [31:0]      ctrl_rdata_o,
  output logic             mem_req_o,
  output logic [PTR_W-1:0] mem_addr_o,
  input  logic [31:0]      mem_rdata_i,
  output logic             mth_valid_o,
  output logic [2:0]       mth_subch_o,
  output logic [12:0]      mth_addr_o,
  output logic [31:0]      mth_handle_o,
  output logic [31:0]      mth_data_o,
  output logic             err_o,
  output logic             idle_o
);
  logic [PTR_W-1:0] put_w, get_w;
  logic             word_vld;
  logic             put_we;

  assign put_we = ctrl_we_i && (ctrl_addr_i == PUT_OFS);

  always_comb begin
    ctrl_rdata_o = '0;
    if (ctrl_addr_i == PUT_OFS) ctrl_rdata_o = 32'(put_w);
    else if (ctrl_addr_i == GET_OFS) ctrl_rdata_o = 32'(get_w);
  end

  cfd_fetch #(.RING_WORDS(RING_WORDS)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .put_we_i   (put_we),
    .put_i      (ctrl_wdata_i[PTR_W-1:0]),
    .put_o      (put_w),
    .get_o      (get_w),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .word_vld_o (word_vld),
    .idle_o     (idle_o)
  );

  cfd_decode u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_vld_i   (word_vld),
    .word_i       (mem_rdata_i),
    .mth_valid_o  (mth_valid_o),
    .mth_subch_o  (mth_subch_o),
    .mth_addr_o   (mth_addr_o),
    .mth_handle_o (mth_handle_o),
    .mth_data_o   (mth_data_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
  parameter int unsigned RING_WORDS = 64,
  localparam int unsigned PTR_W = $clog2(RING_WORDS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_o,
  input logic [PTR_W-1:0] get_w,
  input logic             mth_valid_o,
  input logic [12:0]      mth_addr_o,
  input logic             err_o,
  input logic             idle_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RING_WORDS - 1);

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (get_w == (($past(get_w) == LAST) ? '0 : $past(get_w) + 1'b1)));

  assert_idle_no_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_req_o);

  assert_write_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mth_valid_o |-> $past(mem_req_o, 2));

  assert_err_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(mem_req_o, 2));

  assert_err_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && mth_valid_o));

  assert_bind_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mth_valid_o |-> (mth_addr_o != '0));
endmodule

bind cmd_fifo_decoder cfd_checker #(.RING_WORDS(RING_WORDS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .get_w       (get_w),
  .mth_valid_o (mth_valid_o),
  .mth_addr_o  (mth_addr_o),
  .err_o       (err_o),
  .idle_o      (idle_o)
);

// File: tb/cmd_fifo_decoder_test.sv
module cmd_fifo_decoder_test;
  localparam int RING = 64;
  localparam int PW   = $clog2(RING);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          ctrl_we = 1'b0;
  logic [7:0]    ctrl_addr = '0;
  logic [31:0]   ctrl_wdata = '0, ctrl_rdata, mem_rdata = '0;
  logic          mem_req, mth_valid, err, idle;
  logic [PW-1:0] mem_addr;
  logic [2:0]    mth_subch;
  logic [12:0]   mth_addr;
  logic [31:0]   mth_handle, mth_data;
  logic [31:0]   mem [RING];

  cmd_fifo_decoder #(.RING_WORDS(RING)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_addr_i(ctrl_addr),
    .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mth_valid_o(mth_valid),
    .mth_subch_o(mth_subch), .mth_addr_o(mth_addr), .mth_handle_o(mth_handle),
    .mth_data_o(mth_data), .err_o(err), .idle_o(idle));

  always_ff @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

  typedef struct packed {
    logic        e;
    logic [2:0]  sc;
    logic [12:0] a;
    logic [31:0] h;
    logic [31:0] d;
  } exp_t;

  exp_t   expq[$];
  int     checks = 0, fails = 0;
  int     wp = 0, pending = 0;
  int     m_cnt = 0, m_sc = 0, m_mth = 0;
  logic [31:0] m_h [8];
  bit     m_b [8];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int cnt, input int sc, input int mb);
    return {3'b0, 11'(cnt), 2'b0, 3'(sc), 11'(mb >> 2), 2'b0};
  endfunction

  // behavioural model of one ring word
  task automatic model_word(input logic [31:0] w);
    exp_t x;
    if (m_cnt == 0) begin
      m_cnt = int'(w[28:18]); m_sc = int'(w[15:13]); m_mth = int'(w[12:2]);
    end else begin
      if (m_mth == 0) begin
        m_h[m_sc] = w; m_b[m_sc] = 1'b1;
      end else begin
        x.e = !m_b[m_sc]; x.sc = 3'(m_sc); x.a = 13'(m_mth * 4);
        x.h = m_h[m_sc]; x.d = w;
        expq.push_back(x);
      end
      m_cnt--; m_mth = (m_mth + 1) % 2048;
    end
  endtask

  task automatic put_word(input logic [31:0] w);
    mem[wp] = w;
    model_word(w);
    wp = (wp + 1) % RING;
    pending++;
  endtask

  task automatic ctrl_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_addr = a; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_addr = 8'h00;
  endtask

  task automatic ctrl_rd(input logic [7:0] a, output logic [31:0] d);
    ctrl_addr = a; #1; d = ctrl_rdata; ctrl_addr = 8'h00;
  endtask

  // write pointer, then wait for idle and check cycle count and pointers
  task automatic kick(input string req);
    int cyc, n;
    logic [31:0] r;
    n = pending; pending = 0;
    ctrl_wr(8'h40, 32'(wp));
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!idle && cyc < 500);
    chk(cyc == n + 1, "R3 burst timing", 64'(cyc), 64'(n + 1));
    repeat (2) @(negedge clk);
    ctrl_rd(8'h44, r);
    chk(r == 32'(wp), req, 64'(r), 64'(wp));
    chk(!mem_req && idle, "R3 idle", {63'b0, mem_req}, 64'd0);
  endtask

  // compare outputs against the model every cycle
  always @(negedge clk) begin
    if (rst_n && (mth_valid || err)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6 unexpected output", {62'b0, mth_valid, err}, 64'd0);
      end else begin
        exp_t x;
        x = expq.pop_front();
        if (x.e) begin
          chk(err && !mth_valid, "R9 dropped write", {62'b0, err, mth_valid}, 64'h2);
        end else begin
          chk(mth_valid && !err && mth_subch == x.sc && mth_addr == x.a,
              "R6 write addr/subch", {48'b0, mth_subch, mth_addr}, {48'b0, x.sc, x.a});
          chk(mth_handle == x.h && mth_data == x.d, "R6 R10 handle/data",
              {mth_handle, mth_data}, {x.h, x.d});
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < RING; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) begin m_h[i] = '0; m_b[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    ctrl_rd(8'h40, r); chk(r == 0, "R1 put", 64'(r), 0);
    ctrl_rd(8'h44, r); chk(r == 0, "R1 get", 64'(r), 0);
    chk(idle && !mth_valid && !err, "R1 outputs", {61'b0, idle, mth_valid, err}, 64'h4);
    // R2 read pointer not host-writable, unknown offset reads 0
    ctrl_wr(8'h44, 32'd5);
    ctrl_rd(8'h44, r); chk(r == 0, "R2 get write ignored", 64'(r), 0);
    chk(idle, "R2 no fetch", {63'b0, idle}, 1);
    ctrl_rd(8'h50, r); chk(r == 0, "R2 other offset", 64'(r), 0);
    // R9 unbound subchannel
    put_word(hdr(2, 3, 'h100)); put_word(32'h1111); put_word(32'h2222);
    kick("R9 get");
    // R7 bind, R5 R6 burst
    put_word(hdr(1, 1, 0)); put_word(32'hA0A0_0001);
    put_word(hdr(3, 1, 'h30c));
    put_word(32'hD0); put_word(32'hD1); put_word(32'hD2);
    kick("R5 R6 get");
    ctrl_rd(8'h40, r); chk(r == 32'(wp), "R2 put readback", 64'(r), 64'(wp));
    // R8 NOPs interleaved
    put_word('0); put_word('0);
    put_word(hdr(1, 1, 'h1ffc)); put_word(32'hE1);
    put_word('0);
    kick("R8 get");
    // R7 bind then write within one command
    put_word(hdr(2, 5, 0)); put_word(32'hB5B5_0005); put_word(32'hF4);
    kick("R7 get");
    // R10 rebind sc1, sc5 unaffected
    put_word(hdr(1, 1, 0)); put_word(32'hC1C1_0011);
    put_word(hdr(1, 1, 'h40)); put_word(32'h41);
    put_word(hdr(1, 5, 'h80)); put_word(32'h81);
    kick("R10 get");
    // R11 split command across updates
    put_word(hdr(2, 5, 'h200));
    kick("R11 header get");
    put_word(32'h5A); put_word(32'h5B);
    kick("R11 data get");
    // R4 wrap: push long bursts past ring end
    for (int k = 0; k < 3; k++) begin
      put_word(hdr(12, 1, 'h400 + k * 64));
      for (int j = 0; j < 12; j++) put_word(32'(k * 100 + j));
      kick("R4 wrap get");
    end
    chk(expq.size() == 0, "R6 all writes seen", 64'(expq.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule